// File: doc/BRIEF.md
# Interrupt Trigger Normalizer

This block sits between a bank of raw interrupt lines and a downstream interrupt controller that accepts only active-high levels and rising edges. Each line has its own small configuration register that selects one of five trigger types and carries an enable bit. The block synchronizes each raw line, inverts it when the selected type is active-low or falling-edge, and then presents either the resulting level or a single-cycle rising-edge pulse downstream.

Software reaches the per-line registers and a fixed read-only version word through a simple single-cycle request port. Read data returns one clock after the request. The inversion is applied before edge detection. Because of this, changing a line's trigger type while its input is steady can flip the normalized level and produce one spurious pulse. The block models this behaviour on purpose so that software can clear it.

Top module: `trig_normalizer`

## Requirements
- R1: After reset every output is low and every configuration register reads 0.
- R2: The configuration register of line i is at byte address 0x110 + 4*i. It holds write-data bits [3:0] and reads them back exactly, with bits [31:4] reading 0. Read data appears on the clock edge after the read request.
- R3: A read of address 0x1000 returns 0x30200. A read of any unmapped address returns 0.
- R4: While bit 3 (enable) of a line's register is 0, that line's output is low.
- R5: Type 3'b100 (level, active high) drives the output to follow the synchronized input. An input change shows at the output on the third rising clock edge after it is applied.
- R6: Type 3'b000 (level, active low) drives the output to the inverse of the synchronized input.
- R7: Type 3'b110 (rising edge) gives exactly one single-cycle output pulse per rising input edge and none on a falling edge.
- R8: Type 3'b010 (falling edge) gives exactly one single-cycle pulse per falling input edge and none on a rising edge.
- R9: Type 3'b111 (dual edge) gives exactly one single-cycle pulse for each rising and each falling input edge.
- R10: Any type code outside the five above keeps the output low. The register still reads back the written value.
- R11: A type change that flips the normalized level of a steady input produces exactly one output pulse, for example rising-edge to falling-edge with the input low. Rewriting an unchanged type produces none.
- R12: Each line's output depends only on that line's input and register.
- R13: A read-modify-write that changes only bits [2:0] keeps the enable bit that was read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read request |
| line_in | input | LINES | Raw asynchronous interrupt lines |
| irq_out | output | LINES | Normalized outputs to the downstream controller |

## Verification
Each trigger type is driven with a steady input, then a rising input, then a falling input. Pulses are counted over a window, so a missing inversion, a doubled pulse and a pulse on the wrong edge each give a different count. Level modes are sampled cycle by cycle to pin the three-edge latency. Type rewrites with a steady input separate a real level flip, which must give one phantom pulse, from an unchanged rewrite, which must give none. Disabled and unlisted codes are shown to stay silent while the input toggles.

// File: rtl/trig_normalizer.sv
module trig_normalizer #(
  parameter int LINES  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  input  logic [LINES-1:0]  line_in,
  output logic [LINES-1:0]  irq_out
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(32'h110);
  localparam logic [ADDR_W-1:0] VER_ADDR = ADDR_W'(32'h1000);
  localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(4 * LINES);
  localparam logic [31:0] VERSION = 32'h0003_0200;

  logic [LINES-1:0][3:0] cfg_q;
  logic [LINES-1:0] sync1_q, sync2_q, norm_q;
  logic [LINES-1:0] norm_v, fire_v, ok_v, en_v;

  logic [ADDR_W-1:0] offs;
  logic              hit_cfg;
  logic [IDX_W-1:0]  idx;

  assign offs    = req_addr - CFG_BASE;
  assign hit_cfg = (offs < CFG_SPAN) && (offs[1:0] == 2'b00);
  assign idx     = offs[IDX_W+1:2];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [2:0] trig;
    assign trig      = cfg_q[g][2:0];
    assign en_v[g]   = cfg_q[g][3];
    assign ok_v[g]   = (trig == 3'b000) || (trig == 3'b010) || (trig == 3'b100) ||
                       (trig == 3'b110) || (trig == 3'b111);
    assign norm_v[g] = sync2_q[g] ^ ~trig[2];
    assign fire_v[g] = (trig == 3'b111) ? (norm_v[g] ^ norm_q[g]) :
                       trig[1]          ? (norm_v[g] & ~norm_q[g]) :
                                          norm_v[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      sync1_q   <= '0;
      sync2_q   <= '0;
      norm_q    <= '0;
      irq_out   <= '0;
      rsp_rdata <= '0;
    end else begin
      sync1_q   <= line_in;
      sync2_q   <= sync1_q;
      norm_q    <= norm_v;
      irq_out   <= fire_v & en_v & ok_v;
      rsp_rdata <= '0;
      if (req_valid && req_write && hit_cfg)
        cfg_q[idx] <= req_wdata[3:0];
      if (req_valid && !req_write) begin
        if (hit_cfg)
          rsp_rdata <= {28'd0, cfg_q[idx]};
        else if (req_addr == VER_ADDR)
          rsp_rdata <= VERSION;
      end
    end
  end
endmodule

// File: rtl/trig_normalizer_chk.sv
module trig_normalizer_chk #(
  parameter int LINES  = 8,
  parameter int ADDR_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_write,
  input logic [ADDR_W-1:0]     req_addr,
  input logic [31:0]           rsp_rdata,
  input logic [LINES-1:0][3:0] cfg_q,
  input logic [LINES-1:0]      sync2_q,
  input logic [LINES-1:0]      irq_out
);
  function automatic logic listed(input logic [2:0] t);
    return (t == 3'b000) || (t == 3'b010) || (t == 3'b100) || (t == 3'b110) || (t == 3'b111);
  endfunction

  assert_version_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == ADDR_W'(32'h1000)) |=> (rsp_rdata == 32'h0003_0200));

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    assert_disabled_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_q[g][3]) |-> !irq_out[g]);

    assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_q[g]) == 4'hC) |-> (irq_out[g] == $past(sync2_q[g])));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out[g] && cfg_q[g][2:0] == 3'b110 && $past(cfg_q[g][2:0]) == 3'b110) |=> !irq_out[g]);

    assert_unlisted_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !listed($past(cfg_q[g][2:0])) |-> !irq_out[g]);
  end
endmodule

bind trig_normalizer trig_normalizer_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_rdata(rsp_rdata), .cfg_q(cfg_q),
  .sync2_q(sync2_q), .irq_out(irq_out)
);

// File: tb/trig_normalizer_test.sv
module trig_normalizer_test;
  localparam int LINES = 8;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [LINES-1:0] line_in = '0;
  logic [LINES-1:0] irq_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_normalizer #(.LINES(LINES), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .line_in(line_in), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] cfg_addr(input int i);
    return ADDR_W'(32'h110 + 4 * i);
  endfunction

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic count_pulses(input int idx, output int c);
    c = 0;
    repeat (8) begin
      @(negedge clk);
      if (irq_out[idx]) c++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(irq_out == '0, "R1 outputs", 32'(irq_out), 0);
    bus_read(cfg_addr(0), d);
    chk(d == 0, "R1 cfg0", d, 0);
  endtask

  task automatic t_version();
    logic [31:0] d;
    bus_read(16'h1000, d);
    chk(d == 32'h30200, "R3 version", d, 32'h30200);
    bus_read(16'h0800, d);
    chk(d == 0, "R3 unmapped", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(cfg_addr(2), 32'hFFFF_FFF5);
    bus_read(cfg_addr(2), d);
    chk(d == 32'h5, "R2 readback", d, 32'h5);
    bus_write(cfg_addr(2), 32'h0);
    bus_read(cfg_addr(2), d);
    chk(d == 32'h0, "R2 clear", d, 0);
  endtask

  task automatic t_level_high();
    bus_write(cfg_addr(1), 32'hC);
    settle();
    chk(irq_out[1] == 1'b0, "R5 low in", 32'(irq_out[1]), 0);
    line_in[1] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(irq_out[1] == 1'b0, "R5 latency early", 32'(irq_out[1]), 0);
    @(negedge clk);
    chk(irq_out[1] == 1'b1, "R5 latency", 32'(irq_out[1]), 1);
    chk(irq_out == 8'h02, "R12 others quiet", 32'(irq_out), 32'h02);
    line_in[1] = 1'b0;
    settle();
    chk(irq_out[1] == 1'b0, "R5 follow low", 32'(irq_out[1]), 0);
  endtask

  task automatic t_level_low();
    line_in[3] = 1'b1;
    bus_write(cfg_addr(3), 32'h8);
    settle();
    chk(irq_out[3] == 1'b0, "R6 high in", 32'(irq_out[3]), 0);
    line_in[3] = 1'b0;
    settle();
    chk(irq_out[3] == 1'b1, "R6 low in", 32'(irq_out[3]), 1);
    bus_write(cfg_addr(3), 32'h0);
    settle();
  endtask

  task automatic t_rising();
    int c;
    bus_write(cfg_addr(4), 32'hE);
    settle();
    line_in[4] = 1'b1; count_pulses(4, c);
    chk(c == 1, "R7 rise", c, 1);
    line_in[4] = 1'b0; count_pulses(4, c);
    chk(c == 0, "R7 fall", c, 0);
  endtask

  task automatic t_falling();
    int c;
    line_in[5] = 1'b1;
    settle();
    bus_write(cfg_addr(5), 32'hA);
    settle();
    line_in[5] = 1'b0; count_pulses(5, c);
    chk(c == 1, "R8 fall", c, 1);
    line_in[5] = 1'b1; count_pulses(5, c);
    chk(c == 0, "R8 rise", c, 0);
  endtask

  task automatic t_dual();
    int c;
    bus_write(cfg_addr(6), 32'hF);
    settle();
    line_in[6] = 1'b1; count_pulses(6, c);
    chk(c == 1, "R9 rise", c, 1);
    line_in[6] = 1'b0; count_pulses(6, c);
    chk(c == 1, "R9 fall", c, 1);
  endtask

  task automatic t_disable();
    line_in[7] = 1'b1;
    bus_write(cfg_addr(7), 32'h4);
    settle();
    chk(irq_out[7] == 1'b0, "R4 disabled", 32'(irq_out[7]), 0);
    bus_write(cfg_addr(7), 32'hC);
    settle();
    chk(irq_out[7] == 1'b1, "R4 enabled", 32'(irq_out[7]), 1);
    bus_write(cfg_addr(7), 32'h4);
    settle();
    chk(irq_out[7] == 1'b0, "R4 redisabled", 32'(irq_out[7]), 0);
  endtask

  task automatic t_invalid();
    int c;
    logic [31:0] d;
    bus_write(cfg_addr(0), 32'h9);
    settle();
    line_in[0] = 1'b1; count_pulses(0, c);
    chk(c == 0, "R10 rise", c, 0);
    line_in[0] = 1'b0; count_pulses(0, c);
    chk(c == 0, "R10 fall", c, 0);
    bus_read(cfg_addr(0), d);
    chk(d == 32'h9, "R10 readback", d, 32'h9);
  endtask

  task automatic t_phantom();
    int c;
    bus_write(cfg_addr(4), 32'hE);
    settle();
    bus_write(cfg_addr(4), 32'hA);
    count_pulses(4, c);
    chk(c == 1, "R11 phantom", c, 1);
    bus_write(cfg_addr(4), 32'hA);
    count_pulses(4, c);
    chk(c == 0, "R11 same type", c, 0);
  endtask

  task automatic t_rmw();
    logic [31:0] d;
    bus_read(cfg_addr(1), d);
    bus_write(cfg_addr(1), (d & ~32'h7) | 32'h6);
    bus_read(cfg_addr(1), d);
    chk(d == 32'hE, "R13 enable kept", d, 32'hE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_version();
    t_regs();
    t_level_high();
    t_level_low();
    t_rising();
    t_falling();
    t_dual();
    t_disable();
    t_invalid();
    t_phantom();
    t_rmw();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule